// File: doc/BRIEF.md
# Audio Bit and Frame Clock Generator

This block produces the serial bit clock and the left/right frame clock for an I2S controller operating as clock provider. The two audio master clocks reach it as single-cycle tick enables in the system clock domain, one tick per master-clock half period. A source-select bit picks one of them. A 4-bit ratio code then sets how many selected ticks form one bit-clock half period. The ratio table is not binary: codes 0 to 7 give 1, 2, 4, 8, 16, 32, 64 and 128, codes 8 to 12 give 6, 12, 24, 48 and 96, and codes 13 to 15 are reserved.

Each frame holds two 32-bit slots, so it spans 64 bit clocks. The frame clock changes level every 32 bit clocks. Both clock outputs pass through programmable inversion. Alongside the clocks the block emits single-cycle strobes for the serializer: one at every bit-clock shift edge, and one at every frame-clock transition.

A four-state machine governs the outputs:
- **STOP**: clocks parked at their idle level, output enable low.
- **ACTIVE**: clocks running and strobes delivered.
- **KEEPALIVE**: clocks running, strobes suppressed, for an idle link whose frame clock must keep toggling.
- **FAULT**: a reserved ratio code is present; clocks parked and the error flag raised.

The next state is decided from the inputs on every clock, checked in this order:
1. Controller mode clear → STOP.
2. Reserved code → FAULT.
3. Run request → ACTIVE.
4. Keep-frame bit → KEEPALIVE.
5. Otherwise → STOP.

Top module: `aud_clkgen`

## Requirements
- R1: While reset is asserted and after its release, `clk_oe`, `shift_stb`, `frame_stb` and `cfg_err` are 0, `bck_o` equals `bck_inv` and `frame_o` equals `frm_inv`.
- R2: For ratio codes 0 to 7 in ACTIVE, consecutive `shift_stb` pulses are 2×2^code selected ticks apart.
- R3: For ratio codes 8 to 12 in ACTIVE, consecutive `shift_stb` pulses are 2×6×2^(code−8) selected ticks apart.
- R4: `src_sel`=0 counts `mck_tick_a`; `src_sel`=1 counts `mck_tick_b`.
- R5: The shift edge is the raw bit clock falling. In every cycle with `shift_stb` high, `bck_o` equals `bck_inv`, so with `bck_inv`=0 data changes on the falling edge and is valid on the rising edge.
- R6: `frame_stb` pulses only together with `shift_stb`, once every 32 shift strobes, and `frame_o` changes level in that cycle. After a start from STOP, the first `frame_stb` sets `frame_o` to the right-channel level (NOT `frm_inv`). The left-channel level equals `frm_inv`.
- R7: `frm_inv`=1 inverts `frame_o`, so that the left channel begins on a rising frame-clock edge.
- R8: With `ctrl_mode`=1 and a ratio code of 13 to 15, the block is in FAULT from the next cycle: `cfg_err`=1, `clk_oe`=0, no strobes, and clocks at their idle level.
- R9: With `ctrl_mode`=0 the block is in STOP from the next cycle, whatever `run_req` is.
- R10: With `ctrl_mode`=1, `run_req`=0 and `keep_frame`=1, the block is in KEEPALIVE: `clk_oe`=1, both clocks toggle, and no strobes are issued.
- R11: With `ctrl_mode`=1, `run_req`=0 and `keep_frame`=0, the block is in STOP: `clk_oe`=0, `bck_o`=`bck_inv` and `frame_o`=`frm_inv`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mck_tick_a | input | 1 | Half-period tick of master clock A |
| mck_tick_b | input | 1 | Half-period tick of master clock B |
| src_sel | input | 1 | Master clock select (0 = A, 1 = B) |
| div_code | input | 4 | Ratio code |
| ctrl_mode | input | 1 | Controller (clock provider) mode enable |
| bck_inv | input | 1 | Bit-clock inversion |
| frm_inv | input | 1 | Frame-clock inversion |
| keep_frame | input | 1 | Keep clocks running while the link is idle |
| run_req | input | 1 | Transfer active request |
| bck_o | output | 1 | Bit clock |
| frame_o | output | 1 | Frame (left/right) clock |
| clk_oe | output | 1 | Clock output enable |
| shift_stb | output | 1 | Single-cycle strobe at each shift edge |
| frame_stb | output | 1 | Single-cycle strobe at each frame-clock transition |
| cfg_err | output | 1 | Reserved ratio code present |

## Verification
The assertions relating frame transitions to output levels assume that the inversion bits stay put while a strobe is due, and the property for `frame_o` guards this explicitly with `$stable`. The properties assume nothing about tick spacing. The stimulus changes configuration only while the machine is in STOP, and holds every control steady while periods are measured. Tick A is driven high on every cycle and tick B on every other cycle. This keeps each expected spacing an exact cycle count, and lets the two sources be told apart.

// File: rtl/aud_clkgen_pkg.sv
`timescale 1ns/1ps
package aud_clkgen_pkg;
    typedef enum logic [1:0] {
        ST_STOP      = 2'd0,
        ST_ACTIVE    = 2'd1,
        ST_KEEPALIVE = 2'd2,
        ST_FAULT     = 2'd3
    } clk_state_e;
endpackage

// File: rtl/aud_ratio_lut.sv
`timescale 1ns/1ps
// Maps the ratio code to a half-period length in ticks.
module aud_ratio_lut #(
    parameter int CODE_W  = 4,
    parameter int RATIO_W = 8,
    parameter int POW_CNT = 8,   // codes giving pure powers of two
    parameter int SIX_CNT = 5    // codes giving six times a power of two
) (
    input  logic [CODE_W-1:0]  code,
    output logic [RATIO_W-1:0] ratio,
    output logic               reserved
);
    localparam int SIX_LAST = POW_CNT + SIX_CNT - 1;

    always_comb begin
        ratio    = '0;
        reserved = 1'b0;
        if (int'(code) < POW_CNT) begin
            ratio = RATIO_W'(1) << code;
        end else if (int'(code) <= SIX_LAST) begin
            ratio = RATIO_W'(6) << (code - CODE_W'(POW_CNT));
        end else begin
            reserved = 1'b1;
        end
    end
endmodule

// File: rtl/aud_clk_fsm.sv
`timescale 1ns/1ps
module aud_clk_fsm
    import aud_clkgen_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_mode,
    input  logic reserved,
    input  logic run_req,
    input  logic keep_frame,
    output logic running,
    output logic active,
    output logic oe,
    output logic fault
);
    clk_state_e state_q, state_d;

    always_comb begin
        if (!ctrl_mode)      state_d = ST_STOP;
        else if (reserved)   state_d = ST_FAULT;
        else if (run_req)    state_d = ST_ACTIVE;
        else if (keep_frame) state_d = ST_KEEPALIVE;
        else                 state_d = ST_STOP;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_STOP;
        else        state_q <= state_d;
    end

    always_comb begin
        running = 1'b0;
        active  = 1'b0;
        oe      = 1'b0;
        fault   = 1'b0;
        unique case (state_q)
            ST_STOP:      ;
            ST_ACTIVE:    begin running = 1'b1; active = 1'b1; oe = 1'b1; end
            ST_KEEPALIVE: begin running = 1'b1; oe = 1'b1; end
            ST_FAULT:     fault = 1'b1;
            default:      ;
        endcase
    end
endmodule

// File: rtl/aud_clk_counter.sv
`timescale 1ns/1ps
// Tick divider, bit-slot index and frame phase.
module aud_clk_counter #(
    parameter int RATIO_W   = 8,
    parameter int SLOT_BITS = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               running,
    input  logic               tick,
    input  logic [RATIO_W-1:0] ratio,
    output logic               bck_raw,
    output logic               frame_raw,
    output logic               shift_raw,
    output logic               fedge_raw
);
    localparam int IDX_W = $clog2(2 * SLOT_BITS);
    localparam logic [IDX_W-1:0] HALF_LAST = IDX_W'(SLOT_BITS - 1);
    localparam logic [IDX_W-1:0] LAST      = IDX_W'(2 * SLOT_BITS - 1);

    logic [RATIO_W-1:0] div_cnt;
    logic [IDX_W-1:0]   idx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_cnt   <= '0;
            idx       <= '0;
            bck_raw   <= 1'b0;
            frame_raw <= 1'b0;
            shift_raw <= 1'b0;
            fedge_raw <= 1'b0;
        end else if (!running) begin
            div_cnt   <= '0;
            idx       <= '0;
            bck_raw   <= 1'b0;
            frame_raw <= 1'b0;
            shift_raw <= 1'b0;
            fedge_raw <= 1'b0;
        end else begin
            shift_raw <= 1'b0;
            fedge_raw <= 1'b0;
            if (tick) begin
                if (div_cnt >= ratio - RATIO_W'(1)) begin
                    div_cnt <= '0;
                    bck_raw <= ~bck_raw;
                    if (bck_raw) begin
                        shift_raw <= 1'b1;
                        idx       <= (idx == LAST) ? '0 : idx + IDX_W'(1);
                        if (idx == HALF_LAST || idx == LAST) begin
                            frame_raw <= ~frame_raw;
                            fedge_raw <= 1'b1;
                        end
                    end
                end else begin
                    div_cnt <= div_cnt + RATIO_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/aud_clkgen.sv
`timescale 1ns/1ps
module aud_clkgen #(
    parameter int CODE_W    = 4,
    parameter int RATIO_W   = 8,
    parameter int SLOT_BITS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mck_tick_a,
    input  logic              mck_tick_b,
    input  logic              src_sel,
    input  logic [CODE_W-1:0] div_code,
    input  logic              ctrl_mode,
    input  logic              bck_inv,
    input  logic              frm_inv,
    input  logic              keep_frame,
    input  logic              run_req,
    output logic              bck_o,
    output logic              frame_o,
    output logic              clk_oe,
    output logic              shift_stb,
    output logic              frame_stb,
    output logic              cfg_err
);
    logic [RATIO_W-1:0] ratio;
    logic reserved, running, active, oe, fault;
    logic bck_raw, frame_raw, shift_raw, fedge_raw;
    logic tick;

    assign tick = src_sel ? mck_tick_b : mck_tick_a;

    aud_ratio_lut #(.CODE_W(CODE_W), .RATIO_W(RATIO_W)) u_lut (
        .code(div_code), .ratio(ratio), .reserved(reserved)
    );

    aud_clk_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .ctrl_mode(ctrl_mode), .reserved(reserved),
        .run_req(run_req), .keep_frame(keep_frame),
        .running(running), .active(active), .oe(oe), .fault(fault)
    );

    aud_clk_counter #(.RATIO_W(RATIO_W), .SLOT_BITS(SLOT_BITS)) u_cnt (
        .clk(clk), .rst_n(rst_n), .running(running), .tick(tick), .ratio(ratio),
        .bck_raw(bck_raw), .frame_raw(frame_raw),
        .shift_raw(shift_raw), .fedge_raw(fedge_raw)
    );

    assign bck_o     = (bck_raw & running) ^ bck_inv;
    assign frame_o   = (frame_raw & running) ^ frm_inv;
    assign clk_oe    = oe;
    assign cfg_err   = fault;
    assign shift_stb = shift_raw & active;
    assign frame_stb = fedge_raw & active;
endmodule

// File: rtl/aud_clkgen_chk.sv
`timescale 1ns/1ps
module aud_clkgen_chk #(
    parameter int CODE_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CODE_W-1:0] div_code,
    input logic              ctrl_mode,
    input logic              bck_inv,
    input logic              frm_inv,
    input logic              bck_o,
    input logic              frame_o,
    input logic              clk_oe,
    input logic              shift_stb,
    input logic              frame_stb,
    input logic              cfg_err
);
    localparam logic [CODE_W-1:0] RSV_FIRST = CODE_W'(13);

    p_shift_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
        shift_stb |-> (bck_o == bck_inv));

    p_frame_on_shift_r6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_stb |-> shift_stb);

    p_frame_toggles_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_stb && $stable(frm_inv)) |-> (frame_o != $past(frame_o)));

    p_reserved_fault_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_mode && div_code >= RSV_FIRST) |=> (cfg_err && !clk_oe));

    p_fault_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> (!clk_oe && !shift_stb && !frame_stb));

    p_no_ctrl_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_mode |=> (!clk_oe && !cfg_err));

    p_parked_level_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_oe |-> (bck_o == bck_inv && frame_o == frm_inv));
endmodule

bind aud_clkgen aud_clkgen_chk #(.CODE_W(CODE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .div_code(div_code), .ctrl_mode(ctrl_mode),
    .bck_inv(bck_inv), .frm_inv(frm_inv), .bck_o(bck_o), .frame_o(frame_o),
    .clk_oe(clk_oe), .shift_stb(shift_stb), .frame_stb(frame_stb),
    .cfg_err(cfg_err)
);

// File: tb/aud_clkgen_test.sv
`timescale 1ns/1ps
module aud_clkgen_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mck_tick_a = 1'b1;
    logic mck_tick_b = 1'b0;
    logic src_sel = 1'b0;
    logic [3:0] div_code = 4'd0;
    logic ctrl_mode = 1'b0, bck_inv = 1'b0, frm_inv = 1'b0;
    logic keep_frame = 1'b0, run_req = 1'b0;
    logic bck_o, frame_o, clk_oe, shift_stb, frame_stb, cfg_err;

    int n_vec = 0;
    int n_bad = 0;

    always #4 clk = ~clk;   // 125 MHz

    aud_clkgen uut (
        .clk(clk), .rst_n(rst_n), .mck_tick_a(mck_tick_a), .mck_tick_b(mck_tick_b),
        .src_sel(src_sel), .div_code(div_code), .ctrl_mode(ctrl_mode),
        .bck_inv(bck_inv), .frm_inv(frm_inv), .keep_frame(keep_frame),
        .run_req(run_req), .bck_o(bck_o), .frame_o(frame_o), .clk_oe(clk_oe),
        .shift_stb(shift_stb), .frame_stb(frame_stb), .cfg_err(cfg_err)
    );

    // tick B arrives on every other cycle
    initial begin
        forever begin
            @(negedge clk);
            mck_tick_b = ~mck_tick_b;
        end
    end

    typedef struct packed {
        logic       src;
        logic [3:0] code;
        logic       binv;
        logic       finv;
        int         period;   // cycles between shift strobes
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{1'b0, 4'd0,  1'b0, 1'b0, 2},    // R2 ratio 1
        '{1'b0, 4'd3,  1'b1, 1'b0, 16},   // R2 ratio 8, R5 inverted
        '{1'b0, 4'd7,  1'b0, 1'b0, 256},  // R2 ratio 128
        '{1'b1, 4'd3,  1'b0, 1'b0, 32},   // R4 source B, ratio 8
        '{1'b0, 4'd8,  1'b0, 1'b0, 12},   // R3 ratio 6
        '{1'b1, 4'd9,  1'b1, 1'b0, 48},   // R3 ratio 12, R4 source B
        '{1'b0, 4'd12, 1'b0, 1'b1, 192},  // R3 ratio 96
        '{1'b0, 4'd5,  1'b1, 1'b1, 64}    // R2 ratio 32
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic wait_shift(output int cycles);
        cycles = 0;
        do begin cyc(1); cycles++; end while (!shift_stb && cycles < 5000);
    endtask

    task automatic wait_frame(output int cycles);
        cycles = 0;
        do begin cyc(1); cycles++; end while (!frame_stb && cycles < 5000);
    endtask

    task automatic park();
        run_req = 1'b0; keep_frame = 1'b0; ctrl_mode = 1'b1;
        cyc(3);
    endtask

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        int c;
        int flips, bflips, strobes;
        logic last_f, last_b;

        // R1 during reset
        cyc(2);
        check(!clk_oe && !shift_stb && !frame_stb && !cfg_err, "R1 reset outputs",
              {clk_oe, shift_stb, frame_stb, cfg_err}, 0);
        check(bck_o == bck_inv && frame_o == frm_inv, "R1 reset levels",
              {bck_o, frame_o}, {bck_inv, frm_inv});
        rst_n = 1'b1;
        cyc(2);
        check(!clk_oe && !cfg_err && !shift_stb, "R1 after release",
              {clk_oe, cfg_err, shift_stb}, 0);

        // table of ratio / source / polarity vectors
        foreach (VECS[i]) begin
            park();
            src_sel = VECS[i].src; div_code = VECS[i].code;
            bck_inv = VECS[i].binv; frm_inv = VECS[i].finv;
            run_req = 1'b1;
            wait_shift(c);
            check(bck_o == bck_inv, "R5 bck level at shift", bck_o, bck_inv);
            wait_shift(c);
            check(c == VECS[i].period, "R2/R3/R4 shift period", c, VECS[i].period);
            check(clk_oe, "R2 output enabled", clk_oe, 1);
        end

        // R6 frame timing and level, no inversion
        park();
        src_sel = 1'b0; div_code = 4'd0; bck_inv = 1'b0; frm_inv = 1'b0;
        run_req = 1'b1;
        wait_frame(c);
        check(frame_o == 1'b1, "R6 first frame edge right channel", frame_o, 1);
        check(shift_stb, "R6 frame edge on shift", shift_stb, 1);
        wait_frame(c);
        check(c == 64, "R6 frame half period", c, 64);
        check(frame_o == 1'b0, "R6 left channel level", frame_o, 0);

        // R7 frame inversion
        park();
        frm_inv = 1'b1;
        run_req = 1'b1;
        wait_frame(c);
        check(frame_o == 1'b0, "R7 inverted right channel", frame_o, 0);
        wait_frame(c);
        check(frame_o == 1'b1, "R7 inverted left channel", frame_o, 1);
        frm_inv = 1'b0;

        // R8 reserved codes
        for (int code = 13; code <= 15; code++) begin
            park();
            div_code = 4'(code); run_req = 1'b1;
            cyc(2);
            check(cfg_err && !clk_oe, "R8 fault flag", {cfg_err, clk_oe}, 2);
            strobes = 0; bflips = 0; last_b = bck_o;
            for (int k = 0; k < 40; k++) begin
                cyc(1);
                if (shift_stb || frame_stb) strobes++;
                if (bck_o != last_b) bflips++;
                last_b = bck_o;
            end
            check(strobes == 0 && bflips == 0, "R8 clocks halted", strobes + bflips, 0);
        end
        div_code = 4'd2;
        cyc(2);
        check(!cfg_err && clk_oe, "R8 recovery", {cfg_err, clk_oe}, 1);

        // R9 controller mode off
        ctrl_mode = 1'b0; div_code = 4'd0;
        cyc(2);
        check(!clk_oe, "R9 controller mode off", clk_oe, 0);
        bflips = 0; last_b = bck_o;
        for (int k = 0; k < 40; k++) begin
            cyc(1);
            if (bck_o != last_b || shift_stb) bflips++;
            last_b = bck_o;
        end
        check(bflips == 0, "R9 clocks quiet", bflips, 0);

        // R10 keep-alive
        ctrl_mode = 1'b1; run_req = 1'b0; keep_frame = 1'b1;
        cyc(3);
        check(clk_oe, "R10 keepalive enabled", clk_oe, 1);
        flips = 0; bflips = 0; strobes = 0; last_f = frame_o; last_b = bck_o;
        for (int k = 0; k < 200; k++) begin
            cyc(1);
            if (frame_o != last_f) flips++;
            if (bck_o != last_b) bflips++;
            if (shift_stb || frame_stb) strobes++;
            last_f = frame_o; last_b = bck_o;
        end
        check(flips >= 2, "R10 frame keeps toggling", flips, 2);
        check(bflips > 0, "R10 bit clock running", bflips, 1);
        check(strobes == 0, "R10 strobes suppressed", strobes, 0);

        // R11 idle stop
        keep_frame = 1'b0; bck_inv = 1'b1; frm_inv = 1'b1;
        cyc(3);
        check(!clk_oe, "R11 stop disabled", clk_oe, 0);
        check(bck_o == 1'b1 && frame_o == 1'b1, "R11 parked levels", {bck_o, frame_o}, 3);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule